// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps a 16-bit-wide multiplexed-address DRAM alive and usable. After reset it holds the bus idle for the power-up pause, then issues a burst of CAS-before-RAS refresh cycles. Only after that does it let the access sequencer use the bus. In normal operation an interval timer raises one refresh demand per slot, so that every row is visited once per retention period. The slot length is derived from the row-address width and the clock period. Each demand is served with a CAS-before-RAS cycle as soon as the bus is free.

The access sequencer holds `acc_req` high for as long as it needs the bus and gets `acc_gnt` back. While the grant is up this block drives its strobes inactive and lowers `bus_own`. There is no data stream at this edge, so no valid/ready pair is used. The grant is a plain level handshake, and the controller never takes the bus back while `acc_req` is high. Refresh demands that arrive during an access are counted and served back to back once the access ends. They go ahead of any waiting access.

Raising `sr_req` parks the device in self refresh with a long CAS-before-RAS cycle. Lowering it brings the device out again, followed by the single catch-up refresh that evenly spaced refresh requires.

Top module: `dram_rfsh_ctrl`

## Requirements
- R1: From reset, `ras_n`, every `cas_n` bit and `we_n` are 1, `bus_own` is 1, and `acc_gnt` and `init_done` are 0. No strobe falls during the power-up pause of PAUSE_NS (10000 cycles at the defaults).
- R2: After the pause exactly INIT_CYCLES (8) CAS-before-RAS cycles run. `init_done` then rises, and `acc_gnt` is never 1 before that.
- R3: In every refresh cycle all CAS lanes fall at least one cycle before `ras_n` falls and stay low for as long as `ras_n` is low. RAS and CAS rise together. In a normal refresh `ras_n` is low for 6 cycles. Before CAS falls, all strobes have been high for at least 4 cycles.
- R4: `we_n` is 1 in every cycle, so no refresh can be read as test-mode entry.
- R5: Once `init_done` is 1, one refresh demand arises every floor(retention / 2^ROW_BITS / CLK_PERIOD_NS) cycles. The retention is 64 ms for 12 row bits and 128 ms for 13. That is 1562 cycles at the defaults. In steady state successive RAS falls are that far apart.
- R6: `acc_gnt` rises only from idle when no refresh is owed and `sr_req` is 0. It stays 1 while `acc_req` is 1, and falls in the cycle after `acc_req` is seen at 0. `bus_own` is its inverse.
- R7: A refresh that falls due during a grant is served after the grant ends and before any new grant. The priority order is owed refresh, then self-refresh entry, then access.
- R8: Up to MAX_PENDING (4) owed refreshes are kept. A demand that arrives while 4 are owed and none is starting sets `pend_err`, which stays 1 until reset. The owed refreshes then run back to back.
- R9: With `sr_req` high in idle, the block starts a CAS-before-RAS cycle and raises `sr_active`. `ras_n` stays low for at least SREF_MIN_NS (10000 cycles) and for as long as `sr_req` stays 1.
- R10: On exit, RAS and CAS go high together. RAS then stays high for 10 cycles: 9 cycles of exit precharge plus one CAS lead cycle. Exactly one CAS-before-RAS cycle follows before any grant.
- R11: In self refresh the interval timer and the owed count are cleared. Timing restarts at exit, so the first periodic RAS fall comes 1564 cycles after the exit RAS rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access sequencer wants or holds the bus |
| sr_req | input | 1 | Level request to enter and remain in self refresh |
| acc_gnt | output | 1 | Bus granted to the access sequencer |
| bus_own | output | 1 | This block drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LANES | Column strobes for each byte lane, active low |
| we_n | output | 1 | Write strobe, held high |
| init_done | output | 1 | Power-up sequence finished |
| sr_active | output | 1 | Device is entering or in self refresh |
| pend_err | output | 1 | Owed-refresh limit exceeded (sticky) |

## Verification
The interesting collision is a timer demand that lands in the same cycle as the controller leaving idle. That happens either because it takes an owed refresh, so the count must stay the same, or because it grants a waiting access. The bench provokes this by sweeping the length of back-to-back short accesses across a timer slot, so that the release lands on every phase near a demand. A behavioural model updated every clock predicts the strobes, grant and error flag, and any disagreement in any cycle is reported.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_HOST,
    ST_PRECH,
    ST_CASLEAD,
    ST_RASLOW,
    ST_SELF
  } rfsh_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int per);
    int r;
    r = (ns + per - 1) / per;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
  parameter int MAXP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  input  logic take,
  output logic has_pending,
  output logic overflow_err
);
  localparam int PW = $clog2(MAXP + 1);

  logic [PW-1:0] owed;
  logic          full;

  assign full        = (owed == PW'(MAXP));
  assign has_pending = (owed != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed         <= '0;
      overflow_err <= 1'b0;
    end else if (clear) begin
      owed <= '0;
    end else begin
      if (tick && !take && !full) owed <= owed + 1'b1;
      else if (take && !tick)     owed <= owed - 1'b1;
      if (tick && !take && full)  overflow_err <= 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
  import dram_rfsh_pkg::*;
#(
  parameter int T_PAUSE     = 10000,
  parameter int T_CSR       = 1,
  parameter int T_RAS       = 6,
  parameter int T_RP        = 4,
  parameter int T_RPS       = 9,
  parameter int T_SREF      = 10000,
  parameter int INIT_CYCLES = 8,
  parameter int CW          = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic sr_req,
  input  logic has_pending,
  output logic take,
  output logic ras_low,
  output logic cas_low,
  output logic acc_gnt,
  output logic init_done,
  output logic sr_active
);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  rfsh_state_e   state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] init_cnt;
  logic          is_sr;
  logic          need_x;

  assign init_done = (init_cnt == IW'(INIT_CYCLES));
  assign take      = (state == ST_IDLE) && has_pending;
  assign ras_low   = (state == ST_RASLOW) || (state == ST_SELF);
  assign cas_low   = ras_low || (state == ST_CASLEAD);
  assign acc_gnt   = (state == ST_HOST);
  assign sr_active = is_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PAUSE;
      cnt      <= CW'(T_PAUSE - 1);
      init_cnt <= '0;
      is_sr    <= 1'b0;
      need_x   <= 1'b0;
    end else begin
      unique case (state)
        ST_PAUSE: begin
          if (cnt == '0) begin
            state <= ST_CASLEAD;
            cnt   <= CW'(T_CSR - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (has_pending) begin
            state <= ST_CASLEAD;
            cnt   <= CW'(T_CSR - 1);
          end else if (sr_req) begin
            state <= ST_CASLEAD;
            cnt   <= CW'(T_CSR - 1);
            is_sr <= 1'b1;
          end else if (acc_req) begin
            state <= ST_HOST;
          end
        end
        ST_HOST: begin
          if (!acc_req) begin
            state <= ST_PRECH;
            cnt   <= CW'(T_RP - 1);
          end
        end
        ST_CASLEAD: begin
          if (cnt == '0) begin
            state <= ST_RASLOW;
            cnt   <= is_sr ? CW'(T_SREF - 1) : CW'(T_RAS - 1);
            if (!init_done) init_cnt <= init_cnt + 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_RASLOW: begin
          if (cnt == '0) begin
            if (is_sr) state <= ST_SELF;
            else begin
              state <= ST_PRECH;
              cnt   <= CW'(T_RP - 1);
            end
          end else cnt <= cnt - 1'b1;
        end
        ST_SELF: begin
          if (!sr_req) begin
            state  <= ST_PRECH;
            cnt    <= CW'(T_RPS - 1);
            is_sr  <= 1'b0;
            need_x <= 1'b1;
          end
        end
        ST_PRECH: begin
          if (cnt == '0) begin
            if (!init_done || need_x) begin
              state  <= ST_CASLEAD;
              cnt    <= CW'(T_CSR - 1);
              need_x <= 1'b0;
            end else state <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_rfsh_ctrl.sv
module dram_rfsh_ctrl
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ROW_BITS      = 12,
  parameter int INIT_CYCLES   = 8,
  parameter int MAX_PENDING   = 4,
  parameter int CAS_LANES     = 2,
  parameter int PAUSE_NS      = 100000,
  parameter int SREF_MIN_NS   = 100000,
  parameter int RAS_MIN_NS    = 60,
  parameter int PRECH_NS      = 40,
  parameter int SREF_EXIT_NS  = 90,
  parameter int CAS_SETUP_NS  = 5,
  parameter int CAS_HOLD_NS   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_req,
  input  logic                 sr_req,
  output logic                 acc_gnt,
  output logic                 bus_own,
  output logic                 ras_n,
  output logic [CAS_LANES-1:0] cas_n,
  output logic                 we_n,
  output logic                 init_done,
  output logic                 sr_active,
  output logic                 pend_err
);
  localparam int RETENTION_NS = (ROW_BITS == 13) ? 128_000_000 : 64_000_000;
  localparam int ROWS         = 1 << ROW_BITS;
  localparam int T_REFI       = (RETENTION_NS / ROWS) / CLK_PERIOD_NS;
  localparam int T_PAUSE      = ns_to_cyc(PAUSE_NS, CLK_PERIOD_NS);
  localparam int T_SREF       = ns_to_cyc(SREF_MIN_NS, CLK_PERIOD_NS);
  localparam int T_CSR        = ns_to_cyc(CAS_SETUP_NS, CLK_PERIOD_NS);
  localparam int T_RAS        = max3(ns_to_cyc(RAS_MIN_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(CAS_HOLD_NS, CLK_PERIOD_NS), 1);
  localparam int T_RP         = ns_to_cyc(PRECH_NS, CLK_PERIOD_NS);
  localparam int T_RPS        = ns_to_cyc(SREF_EXIT_NS, CLK_PERIOD_NS);
  localparam int CW           = $clog2(max3(T_PAUSE, T_SREF, T_RAS) + 1);

  logic tick, take, has_pending, ras_low, cas_low, run;

  assign run = init_done && !sr_active;

  rfsh_interval_timer #(.INTERVAL(T_REFI)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  rfsh_pending #(.MAXP(MAX_PENDING)) u_owed (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (sr_active),
    .tick        (tick),
    .take        (take),
    .has_pending (has_pending),
    .overflow_err(pend_err)
  );

  rfsh_sequencer #(
    .T_PAUSE    (T_PAUSE),
    .T_CSR      (T_CSR),
    .T_RAS      (T_RAS),
    .T_RP       (T_RP),
    .T_RPS      (T_RPS),
    .T_SREF     (T_SREF),
    .INIT_CYCLES(INIT_CYCLES),
    .CW         (CW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_req    (acc_req),
    .sr_req     (sr_req),
    .has_pending(has_pending),
    .take       (take),
    .ras_low    (ras_low),
    .cas_low    (cas_low),
    .acc_gnt    (acc_gnt),
    .init_done  (init_done),
    .sr_active  (sr_active)
  );

  assign ras_n   = ~ras_low;
  assign bus_own = ~acc_gnt;
  assign we_n    = 1'b1;

  for (genvar g = 0; g < CAS_LANES; g++) begin : g_lane
    assign cas_n[g] = ~cas_low;
  end
endmodule

// File: rtl/dram_rfsh_ctrl_chk.sv
module dram_rfsh_ctrl_chk #(
  parameter int CAS_LANES = 2,
  parameter int RP_CYC    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_gnt,
  input logic                 ras_n,
  input logic [CAS_LANES-1:0] cas_n,
  input logic                 init_done,
  input logic                 sr_active,
  input logic                 pend_err
);
  logic [7:0] hi_run;
  logic       ras_q, sr_q, owe_cbr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= '0;
      ras_q   <= 1'b1;
      sr_q    <= 1'b0;
      owe_cbr <= 1'b0;
    end else begin
      ras_q <= ras_n;
      sr_q  <= sr_active;
      if (ras_n && (&cas_n)) hi_run <= (hi_run == 8'hFF) ? hi_run : hi_run + 1'b1;
      else                   hi_run <= '0;
      if (sr_q && !sr_active)   owe_cbr <= 1'b1;
      else if (ras_q && !ras_n) owe_cbr <= 1'b0;
    end
  end

  // R3
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(cas_n) == '0);
  // R3
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> cas_n == '0);
  // R3
  strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (&cas_n));
  // R3
  prech_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n[0]) |-> hi_run >= 8'(RP_CYC));
  // R2
  gnt_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> init_done);
  // R6
  gnt_idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (ras_n && (&cas_n)));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_err |=> pend_err);
  // R10
  sr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> (ras_n && !$past(ras_n)));
  // R10
  exit_cbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> !owe_cbr);
endmodule

bind dram_rfsh_ctrl dram_rfsh_ctrl_chk #(
  .CAS_LANES(CAS_LANES),
  .RP_CYC   (T_RP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_gnt  (acc_gnt),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .init_done(init_done),
  .sr_active(sr_active),
  .pend_err (pend_err)
);

// File: tb/dram_rfsh_ctrl_bench.sv
`timescale 1ns/1ps
module dram_rfsh_ctrl_bench;
  // constants taken from the requirements at default parameters
  localparam int PAUSE = 10000, RAS_LEN = 6, PRE = 4, EXIT_PRE = 9;
  localparam int SREF = 10000, REFI = 1562, NINIT = 8, MAXP = 4;

  logic clk = 1'b0, rst_n, acc_req, sr_req;
  logic acc_gnt, bus_own, ras_n, we_n, init_done, sr_active, pend_err;
  logic [1:0] cas_n;

  always #5 clk = ~clk;

  dram_rfsh_ctrl u_dram_rfsh_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .sr_req(sr_req),
    .acc_gnt(acc_gnt), .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .init_done(init_done), .sr_active(sr_active), .pend_err(pend_err)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at cycle", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // mode: 0 pause, 1 idle, 2 host, 3 precharge, 4 cas lead, 5 ras low, 6 self
  int md, left, owed, tmr, ninit;
  bit in_sr, owe_exit, err;
  bit m_run, m_tick, m_take;
  int owed0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md = 0; left = PAUSE - 1; owed = 0; tmr = 0; ninit = 0;
      in_sr = 0; owe_exit = 0; err = 0;
    end else begin
      m_run  = (ninit == NINIT) && !in_sr;
      m_tick = m_run && (tmr == REFI - 1);
      m_take = (md == 1) && (owed > 0);
      owed0  = owed;
      tmr    = (!m_run || m_tick) ? 0 : tmr + 1;
      if (in_sr) owed = 0;
      else begin
        if (m_tick && !m_take && owed0 < MAXP) owed = owed0 + 1;
        else if (m_take && !m_tick) owed = owed0 - 1;
        if (m_tick && !m_take && owed0 == MAXP) err = 1;
      end
      case (md)
        0: if (left == 0) begin md = 4; left = 0; end else left--;
        1: if (owed0 > 0) begin md = 4; left = 0; end
           else if (sr_req) begin md = 4; left = 0; in_sr = 1; end
           else if (acc_req) md = 2;
        2: if (!acc_req) begin md = 3; left = PRE - 1; end
        4: if (left == 0) begin
             md = 5; left = in_sr ? SREF - 1 : RAS_LEN - 1;
             if (ninit < NINIT) ninit++;
           end else left--;
        5: if (left == 0) begin
             if (in_sr) md = 6; else begin md = 3; left = PRE - 1; end
           end else left--;
        6: if (!sr_req) begin md = 3; left = EXIT_PRE - 1; in_sr = 0; owe_exit = 1; end
        3: if (left == 0) begin
             if (ninit < NINIT || owe_exit) begin md = 4; left = 0; owe_exit = 0; end
             else md = 1;
           end else left--;
        default: md = 1;
      endcase
    end
  end

  // ---------------- per-cycle compare and monitors ----------------
  int cyc = 0, falls = 0, last_fall = 0, gnt_early = 0, sr_len = 0, sr_rise = 0;
  logic prev_ras = 1'b1, prev_sr = 1'b0;
  bit e_ras, e_cas, e_gnt;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      e_ras = !(md == 5 || md == 6);
      e_cas = !(md == 4 || md == 5 || md == 6);
      e_gnt = (md == 2);
      chk(ras_n == e_ras, "R3 ras_n", ras_n, e_ras);
      chk(cas_n == {2{e_cas}}, "R3 cas_n", cas_n, {2{e_cas}});
      chk(acc_gnt == e_gnt, "R6 acc_gnt", acc_gnt, e_gnt);
      chk(bus_own == !e_gnt, "R6 bus_own", bus_own, !e_gnt);
      chk(we_n == 1'b1, "R4 we_n", we_n, 1);
      chk(init_done == (ninit == NINIT), "R2 init_done", init_done, ninit == NINIT);
      chk(sr_active == in_sr, "R9 sr_active", sr_active, in_sr);
      chk(pend_err == err, "R8 pend_err", pend_err, err);
      if (prev_ras && !ras_n) begin falls++; last_fall = cyc; end
      if (!prev_ras && ras_n && prev_sr) begin sr_len = cyc - last_fall; sr_rise = cyc; end
      if (acc_gnt && !init_done) gnt_early++;
    end
    prev_ras = ras_n;
    prev_sr  = sr_active;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      summary();
      $finish;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_gnt();
    for (int k = 0; k < 2000 && !acc_gnt; k++) step();
  endtask

  task automatic wait_fall();
    int s;
    s = falls;
    while (falls == s) step();
  endtask

  initial begin
    int s, t1, d;
    rst_n = 1'b0; acc_req = 1'b0; sr_req = 1'b0;
    step(5);
    // R1 reset state {ras,cas[1:0],we,own,gnt,init}
    chk({ras_n, cas_n, we_n, bus_own, acc_gnt, init_done} == 7'b1111100, "R1 reset",
        {ras_n, cas_n, we_n, bus_own, acc_gnt, init_done}, 7'b1111100);
    rst_n = 1'b1;
    step(PAUSE - 10);
    chk(falls == 0, "R1 pause quiet", falls, 0);
    while (!init_done) step();
    chk(falls == NINIT, "R2 init count", falls, NINIT);
    chk(gnt_early == 0, "R2 no early grant", gnt_early, 0);

    // R6 basic grant and release
    acc_req = 1'b1;
    wait_gnt();
    chk(acc_gnt == 1'b1, "R6 grant", acc_gnt, 1);
    step(20);
    acc_req = 1'b0;
    step();
    chk(acc_gnt == 1'b0, "R6 release", acc_gnt, 0);

    // R5 steady refresh spacing
    wait_fall(); t1 = last_fall;
    wait_fall();
    chk(last_fall - t1 == REFI, "R5 interval", last_fall - t1, REFI);

    // R7 refresh owed during access goes first
    acc_req = 1'b1; wait_gnt();
    step(1600);
    s = falls; acc_req = 1'b0; step(); acc_req = 1'b1;
    wait_gnt();
    chk(falls - s >= 1, "R7 refresh before regrant", falls - s, 1);
    chk(pend_err == 1'b0, "R8 no error yet", pend_err, 0);

    // R8 overflow of owed refreshes
    step(5 * REFI + 40);
    chk(pend_err == 1'b1, "R8 overflow", pend_err, 1);
    s = falls; acc_req = 1'b0; step(); acc_req = 1'b1;
    wait_gnt();
    d = falls - s;
    chk(d >= MAXP && d <= MAXP + 1, "R8 drain", d, MAXP);
    acc_req = 1'b0; step(2);

    // collision sweep: short accesses across a timer slot
    for (int i = 0; i < 60; i++) begin
      acc_req = 1'b1; wait_gnt();
      step((i * 7) % 23 + 1);
      acc_req = 1'b0; step();
    end
    chk(pend_err == 1'b1, "R8 sticky", pend_err, 1);

    // R9 self refresh
    sr_req = 1'b1;
    while (!sr_active) step();
    step(SREF + 2000);
    chk(ras_n == 1'b0 && sr_active, "R9 held low", ras_n, 0);
    s = falls; sr_req = 1'b0; acc_req = 1'b1;
    wait_gnt();
    chk(sr_len >= SREF, "R9 low time", sr_len, SREF);
    chk(falls - s == 1, "R10 one exit refresh", falls - s, 1);
    chk(last_fall - sr_rise == EXIT_PRE + 1, "R10 exit gap", last_fall - sr_rise, EXIT_PRE + 1);
    acc_req = 1'b0; step();

    // R11 timer restarts at exit
    wait_fall();
    chk(last_fall - sr_rise == REFI + 2, "R11 restart", last_fall - sr_rise, REFI + 2);

    step(10);
    summary();
    $finish;
  end
endmodule